// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a passive multiplexed LCD panel of 40 segment lines and 4 common lines (160 dots) at quarter duty and third bias. Each output does not carry a voltage. It carries a 2-bit code that selects one of four bias rails (V0..V3), and an external analog switch network turns that code into a voltage. A display memory holds one 4-bit nibble per segment. The block scans that memory onto the panel without help, so software only needs to write the nibbles.

Time comes from a base-clock enable `base_tick`, nominally 32.768 kHz. A prescaler divides this enable down to the common-slot rate, and a 2-bit select picks one of four divide ratios. Each common is active for one slot, and a frame is four slots. After every frame the polarity of all levels flips, so each dot sees zero average DC. A CPU-side port gives synchronous writes and combinational reads of the display memory.

Top module: `lcd_mux_driver`

## Requirements
- R1: When reset is released, every display entry reads 0 and common 0 is the selected common. The first frame is positive, and the slot length is 64 base ticks.
- R2: A common slot lasts exactly 64·2^s ticks of `base_tick`, where s is the latched 2-bit rate select: 0→64, 1→128, 2→256, 3→512.
- R3: The commons are selected in the order 0,1,2,3, one per slot. Common k appears on `com_lvl[2k+1:2k]`. In a positive frame the selected common drives code 3 and the others drive code 1. In a negative frame the selected common drives 0 and the others drive 2.
- R4: Segment n appears on `seg_lvl[2n+1:2n]` and follows bit k of display entry n while common k is selected. In a positive frame a 1 (dot on) drives 0 and a 0 drives 2. In a negative frame a 1 drives 3 and a 0 drives 1.
- R5: The polarity inverts each time the slot of common 3 ends, so frames alternate between positive and negative.
- R6: A write with `cpu_we` high and `cpu_addr` below 40 stores `cpu_wdata` into entry `cpu_addr` at the clock edge. The entry then reads back on `cpu_rdata` and drives its segment from the next cycle on.
- R7: Addresses 40 to 63 store nothing on write and read back as 0.
- R8: A change on `rate_sel` is latched only at a slot boundary, so the slot that is running keeps its length and the new length starts with the next slot.
- R9: While `base_tick` is low, the slot timer, the common index and the polarity hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle enable per base-clock period |
| rate_sel | input | 2 | Slot-length select (divide by 64, 128, 256, 512) |
| cpu_addr | input | 6 | Display memory address |
| cpu_wdata | input | 4 | Write nibble, bit k is the dot at common k |
| cpu_we | input | 1 | Write enable |
| cpu_rdata | output | 4 | Read nibble at `cpu_addr`, 0 above entry 39 |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 80 | Segment level codes, 2 bits per segment |

## Verification
The bench times every slot at every rate setting. A prescaler that tapped the wrong bit, or that failed to clear between slots, would produce a slot of the wrong length. It changes the rate in the middle of a slot, and a design that applied the new rate at once would cut that slot short. It runs two full frames and checks every common and segment code against a model of the nibble pattern. A swapped polarity, a wrong rail choice, or a nibble bit taken for the wrong common therefore shows up as a code mismatch. It also writes and reads the out-of-range addresses, and it holds `base_tick` low for a long stretch to catch a scan that keeps moving without ticks.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_V0 = 2'd0,
        LVL_V1 = 2'd1,
        LVL_V2 = 2'd2,
        LVL_V3 = 2'd3
    } lvl_e;

    // Common rail: extreme rail when selected, inner rail otherwise.
    function automatic logic [LVL_W-1:0] com_level(input logic selected, input logic neg);
        lvl_e l;
        if (!neg) l = selected ? LVL_V3 : LVL_V1;
        else      l = selected ? LVL_V0 : LVL_V2;
        return l;
    endfunction

    // Segment rail: opposite extreme for a lit dot, inner rail otherwise.
    function automatic logic [LVL_W-1:0] seg_level(input logic lit, input logic neg);
        lvl_e l;
        if (!neg) l = lit ? LVL_V0 : LVL_V2;
        else      l = lit ? LVL_V3 : LVL_V1;
        return l;
    endfunction

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
    parameter int TAPS       = 4,
    parameter int BASE_SHIFT = 6,
    localparam int SEL_W     = $clog2(TAPS),
    localparam int CNT_W     = BASE_SHIFT + TAPS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             slot_end
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } presc_t;

    presc_t st_d, st_q;
    logic [TAPS-1:0] tap_full;

    // One terminal-count detector per selectable tap.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_full[t] = &st_q.cnt[BASE_SHIFT+t-1:0];
    end

    assign slot_end = base_tick & tap_full[st_q.sel];

    always_comb begin
        st_d = st_q;
        if (base_tick) begin
            if (tap_full[st_q.sel]) begin
                st_d.cnt = '0;
                st_d.sel = rate_sel;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
    parameter int NUM_SEG = 40,
    parameter int NUM_COM = 4,
    parameter int ADDR_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_COM-1:0]         wdata,
    input  logic                       we,
    output logic [NUM_COM-1:0]         rdata,
    output logic [NUM_SEG*NUM_COM-1:0] all_bits
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SEG - 1);

    typedef struct packed {
        logic [NUM_SEG-1:0][NUM_COM-1:0] mem;
    } ram_t;

    ram_t st_d, st_q;
    logic in_range;

    assign in_range = (addr <= LAST_ADDR);

    always_comb begin
        st_d = st_q;
        if (we && in_range) st_d.mem[addr] = wdata;
    end

    assign rdata    = in_range ? st_q.mem[addr] : '0;
    assign all_bits = st_q.mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
    import lcd_pkg::*;
#(
    parameter int NUM_SEG = 40,
    parameter int NUM_COM = 4,
    localparam int COM_W  = $clog2(NUM_COM)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slot_end,
    input  logic [NUM_SEG*NUM_COM-1:0] all_bits,
    output logic [NUM_COM*LVL_W-1:0]   com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);

    localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

    typedef struct packed {
        logic [COM_W-1:0] com;
        logic             neg;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (slot_end) begin
            if (st_q.com == COM_LAST) begin
                st_d.com = '0;
                st_d.neg = ~st_q.neg;
            end else begin
                st_d.com = st_q.com + COM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        assign com_lvl[k*LVL_W +: LVL_W] = com_level(st_q.com == COM_W'(k), st_q.neg);
    end

    for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
        logic [NUM_COM-1:0] nib;
        assign nib = all_bits[n*NUM_COM +: NUM_COM];
        assign seg_lvl[n*LVL_W +: LVL_W] = seg_level(nib[st_q.com], st_q.neg);
    end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
    parameter int NUM_SEG    = 40,
    parameter int NUM_COM    = 4,
    parameter int RATE_TAPS  = 4,
    parameter int BASE_SHIFT = 6,
    parameter int ADDR_W     = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           base_tick,
    input  logic [$clog2(RATE_TAPS)-1:0]   rate_sel,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [NUM_COM-1:0]             cpu_wdata,
    input  logic                           cpu_we,
    output logic [NUM_COM-1:0]             cpu_rdata,
    output logic [NUM_COM*2-1:0]           com_lvl,
    output logic [NUM_SEG*2-1:0]           seg_lvl
);

    logic                       slot_end;
    logic [NUM_SEG*NUM_COM-1:0] all_bits;

    lcd_prescaler #(
        .TAPS       (RATE_TAPS),
        .BASE_SHIFT (BASE_SHIFT)
    ) i_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .rate_sel  (rate_sel),
        .slot_end  (slot_end)
    );

    lcd_disp_ram #(
        .NUM_SEG (NUM_SEG),
        .NUM_COM (NUM_COM),
        .ADDR_W  (ADDR_W)
    ) i_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .wdata    (cpu_wdata),
        .we       (cpu_we),
        .rdata    (cpu_rdata),
        .all_bits (all_bits)
    );

    lcd_scan #(
        .NUM_SEG (NUM_SEG),
        .NUM_COM (NUM_COM)
    ) i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_end (slot_end),
        .all_bits (all_bits),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk #(
    parameter int NUM_SEG    = 40,
    parameter int NUM_COM    = 4,
    parameter int RATE_TAPS  = 4,
    parameter int BASE_SHIFT = 6,
    parameter int ADDR_W     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 base_tick,
    input logic                 slot_end,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic [NUM_COM-1:0]   cpu_wdata,
    input logic                 cpu_we,
    input logic [NUM_COM-1:0]   cpu_rdata,
    input logic [NUM_COM*2-1:0] com_lvl,
    input logic [NUM_SEG*2-1:0] seg_lvl
);

    localparam logic [15:0]       MIN_LEN   = 16'(1 << BASE_SHIFT);
    localparam logic [15:0]       MAX_LEN   = 16'(1 << (BASE_SHIFT + RATE_TAPS - 1));
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SEG - 1);

    logic [15:0]        tick_cnt;
    logic [15:0]        slot_len;
    logic [NUM_COM-1:0] com_ext;
    logic [NUM_COM-1:0] com_b0;
    logic [NUM_SEG-1:0] seg_b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tick_cnt <= '0;
        else if (base_tick) tick_cnt <= slot_end ? 16'd0 : tick_cnt + 16'd1;
    end

    assign slot_len = tick_cnt + 16'd1;

    for (genvar k = 0; k < NUM_COM; k++) begin : g_c
        assign com_ext[k] = (com_lvl[2*k +: 2] == 2'd0) || (com_lvl[2*k +: 2] == 2'd3);
        assign com_b0[k]  = com_lvl[2*k];
    end
    for (genvar n = 0; n < NUM_SEG; n++) begin : g_s
        assign seg_b0[n] = seg_lvl[2*n];
    end

    // R2: slot ends only on a tick, after a power-of-two tick count within the tap range
    a_r2_slot_len: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |-> (base_tick && ((slot_len & tick_cnt) == 16'd0)
                      && (slot_len >= MIN_LEN) && (slot_len <= MAX_LEN)));

    // R3: exactly one common on an extreme rail
    a_r3_one_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_ext) == 1);

    // R3: common levels only move across a slot boundary
    a_r3_com_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> $stable(com_lvl));

    // R5: all commons on one rail pair, all segments on the other
    a_r5_rail_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        ((&com_b0) || !(|com_b0)) && ((&seg_b0) || !(|seg_b0)) && (seg_b0[0] != com_b0[0]));

    // R6: a stored nibble reads back on the following cycle
    a_r6_write_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr <= LAST_ADDR) |=>
            ((cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_wdata))));

    // R7: unmapped addresses read zero
    a_r7_high_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr > LAST_ADDR) |-> (cpu_rdata == '0));

endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(
    .NUM_SEG    (NUM_SEG),
    .NUM_COM    (NUM_COM),
    .RATE_TAPS  (RATE_TAPS),
    .BASE_SHIFT (BASE_SHIFT),
    .ADDR_W     (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .slot_end  (slot_end),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl)
);

// File: tb/test_lcd_mux_driver.sv
module test_lcd_mux_driver;

    localparam int NSEG = 40;
    localparam int NCOM = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            base_tick;
    logic [1:0]      rate_sel;
    logic [5:0]      cpu_addr;
    logic [3:0]      cpu_wdata;
    logic            cpu_we;
    logic [3:0]      cpu_rdata;
    logic [7:0]      com_lvl;
    logic [79:0]     seg_lvl;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [3:0] model [NSEG];

    always #10 clk = ~clk;

    lcd_mux_driver i_lcd_mux_driver (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .rate_sel  (rate_sel),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .cpu_rdata (cpu_rdata),
        .com_lvl   (com_lvl),
        .seg_lvl   (seg_lvl)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_com(input int k, input int c, input bit neg);
        if (!neg) return (k == c) ? 3 : 1;
        return (k == c) ? 0 : 2;
    endfunction

    function automatic int exp_seg(input int n, input int c, input bit neg);
        bit on = model[n][c];
        if (!neg) return on ? 0 : 2;
        return on ? 3 : 1;
    endfunction

    // R3 R4 R5: full pattern for slot index s counted from reset
    task automatic check_slot(input int s);
        int c = s % 4;
        bit neg = ((s / 4) % 2) == 1;
        for (int k = 0; k < NCOM; k++)
            chk(int'(com_lvl[2*k +: 2]) == exp_com(k, c, neg), "R3 R5", $sformatf("slot %0d com %0d", s, k),
                int'(com_lvl[2*k +: 2]), exp_com(k, c, neg));
        for (int n = 0; n < NSEG; n++)
            chk(int'(seg_lvl[2*n +: 2]) == exp_seg(n, c, neg), "R4 R5", $sformatf("slot %0d seg %0d", s, n),
                int'(seg_lvl[2*n +: 2]), exp_seg(n, c, neg));
    endtask

    task automatic wait_boundary(output int len);
        logic [7:0] prev = com_lvl;
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (com_lvl == prev);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int len;
        int s;
        int cur;
        rst_n = 0; base_tick = 0; rate_sel = 0;
        cpu_addr = 0; cpu_wdata = 0; cpu_we = 0;
        for (int n = 0; n < NSEG; n++) model[n] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: cleared memory, common 0 selected in a positive frame
        check_slot(0);
        for (int a = 0; a < NSEG; a++) begin
            cpu_addr = 6'(a);
            #1;
            chk(cpu_rdata == 4'h0, "R1", $sformatf("reset entry %0d", a), int'(cpu_rdata), 0);
        end

        // R6 R7: write every address with the tick held off
        for (int a = 0; a < 64; a++) begin
            cpu_addr  = 6'(a);
            cpu_wdata = 4'((a * 7 + 3) & 15);
            cpu_we    = 1;
            @(negedge clk);
            if (a < NSEG) model[a] = 4'((a * 7 + 3) & 15);
        end
        cpu_we = 0;
        for (int a = 0; a < 64; a++) begin
            cpu_addr = 6'(a);
            #1;
            if (a < NSEG)
                chk(cpu_rdata == model[a], "R6", $sformatf("readback %0d", a), int'(cpu_rdata), int'(model[a]));
            else
                chk(cpu_rdata == 4'h0, "R7", $sformatf("high read %0d", a), int'(cpu_rdata), 0);
            @(negedge clk);
        end
        // R4 R7: segments reflect only the low entries
        check_slot(0);

        // R9: no ticks, no scan progress
        repeat (700) @(negedge clk);
        chk(com_lvl == 8'b01_01_01_11, "R9", "com hold without ticks", int'(com_lvl), 8'b01_01_01_11);
        check_slot(0);

        // R1 R2 R3 R4 R5: two full frames at the reset rate
        base_tick = 1;
        s = 0;
        for (int i = 0; i < 8; i++) begin
            wait_boundary(len);
            s++;
            chk(len == 64, "R1 R2", $sformatf("slot %0d length", s), len, 64);
            check_slot(s);
        end

        // R6: write while scanning, visible on its segment in the same slot
        wait_boundary(len);
        s++;
        cpu_addr = 6'd5; cpu_wdata = ~model[5]; cpu_we = 1;
        @(negedge clk);
        cpu_we = 0;
        model[5] = ~model[5];
        chk(int'(seg_lvl[11:10]) == exp_seg(5, s % 4, ((s / 4) % 2) == 1), "R6", "live write seg 5",
            int'(seg_lvl[11:10]), exp_seg(5, s % 4, ((s / 4) % 2) == 1));
        wait_boundary(len);
        len = len + 1;
        s++;
        chk(len == 64, "R2", "slot after live write", len, 64);
        check_slot(s);

        // R8 R2: rate change mid-slot keeps current slot, applies to the next
        cur = 64;
        for (int j = 0; j < 4; j++) begin
            int sel = (j + 1) % 4;
            repeat (10) @(negedge clk);
            rate_sel = 2'(sel);
            wait_boundary(len);
            s++;
            chk(len + 10 == cur, "R8", $sformatf("slot after select %0d", sel), len + 10, cur);
            check_slot(s);
            wait_boundary(len);
            s++;
            chk(len == (64 << sel), "R2", $sformatf("length at select %0d", sel), len, 64 << sel);
            check_slot(s);
            cur = 64 << sel;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule